// File: doc/BRIEF.md
# Two-wire serial memory slave engine

This block is the protocol engine of a serial EEPROM that answers on a two-wire bus. A separate line front end supplies it with filtered, clock-synchronous samples of the clock and data lines, plus one-cycle strobes for START and STOP. From these the engine:

- decodes the control byte, the word address and any data bytes;
- drives the acknowledge slot through an open-drain pull-low enable;
- shifts read data out of a 256-byte array.

The array read port is combinational: the engine presents an address and gets the byte back in the same cycle. Write data does not go to the array directly. Each accepted data byte goes to an external page buffer through a one-cycle write strobe. A commit pulse then starts the external self-timed programming cycle. While that cycle runs, the timer raises `busy_i` and the engine refuses every acknowledge. A master can therefore poll for completion by sending the control byte until it is acknowledged.

An internal address pointer survives from one transaction to the next. This gives three kinds of read: current-address reads, random reads (a word address followed by a repeated START), and sequential reads that run across the whole array.

Top module: `twi_mem_slave`

## Requirements
- R1: A control byte is accepted only when its bits [7:4] equal 4'b1010. Bits [3:1] are ignored, and bit 0 selects read (1) or write (0). A mismatching control byte gets no acknowledge, and the engine ignores the bus until the next START.
- R2: An acknowledged byte has `sda_pull_o` high from the first clock cycle after the SCL fall that ends its 8th bit, until the first clock cycle after the SCL fall that ends the 9th clock.
- R3: While `busy_i` is high, no byte (control, address or data) is acknowledged, no data byte is passed to the page buffer, and the engine returns to waiting for a START.
- R4: In a write, the byte after the control byte loads the address pointer. Each following data byte is issued on `buf_we_o` with `buf_addr_o` equal to the pointer, and the pointer then increments.
- R5: `commit_o` pulses for one cycle on a STOP or START strobe, but only if at least one data byte was passed to the page buffer since the previous START. A write transaction that carries no data gives no pulse.
- R6: A repeated START after the word address keeps the loaded pointer, so a following read returns the byte at that address.
- R7: A read returns the byte at the pointer, which is the last accessed address plus one, most significant bit first. `sda_pull_o` changes only in the cycle after an SCL falling edge or after a START/STOP strobe.
- R8: After a read byte, a master acknowledge (SDA low on the 9th clock) makes the engine send the next sequential byte. A master no-acknowledge makes it release SDA and wait for a START.
- R9: The pointer increments after every completed data byte and wraps from 255 to 0.
- R10: A START or STOP strobe at any bit position aborts the current byte. No write is issued and the pointer does not move for that byte. `sda_pull_o` is low in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Filtered bus clock sample |
| sda_i | input | 1 | Filtered bus data sample |
| start_i | input | 1 | One-cycle START strobe from the line front end |
| stop_i | input | 1 | One-cycle STOP strobe from the line front end |
| busy_i | input | 1 | Self-timed programming cycle in progress |
| rd_data_i | input | 8 | Array byte at `rd_addr_o`, combinational |
| sda_pull_o | output | 1 | Pull SDA low (open-drain enable) |
| rd_addr_o | output | 8 | Address pointer, used as the array read address |
| buf_we_o | output | 1 | Data byte strobe to the page buffer |
| buf_addr_o | output | 8 | Page buffer byte address |
| buf_data_o | output | 8 | Page buffer byte data |
| commit_o | output | 1 | Start the programming cycle |

## Verification
The engine registers every SCL edge once, so `sda_pull_o` moves one clock after the SCL fall it answers. `buf_we_o` fires one clock after the SCL fall that ends the 8th bit, and `commit_o` follows a STOP or START strobe by one clock. The bench holds each SCL phase for four clocks and samples the data line at the falling clock edge at the end of the high phase, several cycles after any such update. Commit pulses are counted continuously and compared after each STOP. Read data is checked against an array model that applies buffered writes only on commit.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CTRL,
    PH_WADDR,
    PH_WDATA,
    PH_RDATA
  } phase_e;
endpackage

// File: rtl/twi_scl_edge.sv
module twi_scl_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scl_q <= 1'b1;
    else         scl_q <= scl_i;
  end

  assign rise_o = scl_i & ~scl_q;
  assign fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/twi_addr_ptr.sv
module twi_addr_ptr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;
    else if (inc_i)  ptr_o <= ptr_o + 1'b1;  // natural wrap at the top
  end
endmodule

// File: rtl/twi_shifter.sv
module twi_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_in_i,
  input  logic         bit_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_out_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          q_o <= '0;
    else if (load_i)      q_o <= load_val_i;
    else if (shift_in_i)  q_o <= {q_o[W-2:0], bit_i};
    else if (shift_out_i) q_o <= {q_o[W-2:0], 1'b0};
  end
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave #(
  parameter int         ADDR_W   = 8,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              busy_i,
  input  logic [7:0]        rd_data_i,
  output logic              sda_pull_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              buf_we_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic [7:0]        buf_data_o,
  output logic              commit_o
);
  import twi_mem_pkg::*;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_CLK  = CNT_W'(BYTE_W + 1);

  phase_e             phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               pull_q, rw_q, mack_q, wrote_q, commit_q, we_q;
  logic [ADDR_W-1:0]  baddr_q, ptr;
  logic [BYTE_W-1:0]  bdata_q, sh_q;
  logic               rise, fall;

  twi_scl_edge u_edge (
    .clk_i, .rst_ni, .scl_i, .rise_o(rise), .fall_o(fall)
  );

  wire aborting   = start_i | stop_i;
  wire active     = (phase_q != PH_IDLE) & ~aborting;
  wire rx_phase   = (phase_q == PH_CTRL) | (phase_q == PH_WADDR) | (phase_q == PH_WDATA);
  wire byte_end   = active & fall & (cnt_q == LAST_BIT);
  wire ack_end    = active & fall & (cnt_q == ACK_CLK);
  wire ack_ok     = ~busy_i;
  wire ctrl_match = sh_q[BYTE_W-1 -: 4] == DEV_CODE;

  wire sh_in   = active & rise & rx_phase & (cnt_q < LAST_BIT);
  wire sh_load = ack_end & (((phase_q == PH_CTRL) & rw_q) | ((phase_q == PH_RDATA) & mack_q));
  wire sh_out  = active & fall & (phase_q == PH_RDATA) & (cnt_q != '0) & (cnt_q < LAST_BIT);

  twi_shifter #(.W(BYTE_W)) u_shift (
    .clk_i, .rst_ni,
    .shift_in_i(sh_in), .bit_i(sda_i),
    .load_i(sh_load), .load_val_i(rd_data_i),
    .shift_out_i(sh_out), .q_o(sh_q)
  );

  wire ptr_load = byte_end & (phase_q == PH_WADDR) & ack_ok;
  wire ptr_inc  = byte_end & (((phase_q == PH_WDATA) & ack_ok) | (phase_q == PH_RDATA));

  twi_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk_i, .rst_ni,
    .load_i(ptr_load), .load_val_i(sh_q[ADDR_W-1:0]),
    .inc_i(ptr_inc), .ptr_o(ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      pull_q   <= 1'b0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      wrote_q  <= 1'b0;
      commit_q <= 1'b0;
      we_q     <= 1'b0;
      baddr_q  <= '0;
      bdata_q  <= '0;
    end else begin
      commit_q <= 1'b0;
      we_q     <= 1'b0;
      if (aborting) begin
        commit_q <= wrote_q;
        wrote_q  <= 1'b0;
        phase_q  <= start_i ? PH_CTRL : PH_IDLE;
        cnt_q    <= '0;
        pull_q   <= 1'b0;
      end else if (phase_q != PH_IDLE) begin
        if (rise) begin
          if (cnt_q < LAST_BIT) cnt_q <= cnt_q + 1'b1;
          else if (cnt_q == LAST_BIT) begin
            cnt_q  <= ACK_CLK;
            mack_q <= ~sda_i;
          end
        end
        if (fall) begin
          if (cnt_q == LAST_BIT) begin
            if (phase_q == PH_RDATA) pull_q <= 1'b0;  // master drives its ack
            else if (!ack_ok || (phase_q == PH_CTRL && !ctrl_match)) phase_q <= PH_IDLE;
            else begin
              pull_q <= 1'b1;
              if (phase_q == PH_CTRL) rw_q <= sh_q[0];
              if (phase_q == PH_WDATA) begin
                we_q    <= 1'b1;
                baddr_q <= ptr;
                bdata_q <= sh_q;
                wrote_q <= 1'b1;
              end
            end
          end else if (cnt_q == ACK_CLK) begin
            cnt_q  <= '0;
            pull_q <= 1'b0;
            case (phase_q)
              PH_CTRL: begin
                phase_q <= rw_q ? PH_RDATA : PH_WADDR;
                if (rw_q) pull_q <= ~rd_data_i[BYTE_W-1];
              end
              PH_WADDR: phase_q <= PH_WDATA;
              PH_RDATA: begin
                if (mack_q) pull_q <= ~rd_data_i[BYTE_W-1];
                else        phase_q <= PH_IDLE;
              end
              default: ;
            endcase
          end else if (phase_q == PH_RDATA && cnt_q != '0) begin
            pull_q <= ~sh_q[BYTE_W-2];
          end
        end
      end
    end
  end

  assign sda_pull_o = pull_q;
  assign rd_addr_o  = ptr;
  assign buf_we_o   = we_q;
  assign buf_addr_o = baddr_q;
  assign buf_data_o = bdata_q;
  assign commit_o   = commit_q;
endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic start_i,
  input logic stop_i,
  input logic busy_i,
  input logic sda_pull_o,
  input logic buf_we_o,
  input logic commit_o
);
  // R10: a bus condition always frees the data line
  p_stop_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_pull_o);
  p_start_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !sda_pull_o);
  // R7: data line held while the clock stays high
  p_sda_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && !start_i && !stop_i) |=> $stable(sda_pull_o));
  // R3: nothing reaches the page buffer during programming
  p_no_write_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> !$past(busy_i));
  // R5: commit is a single pulse
  p_commit_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);
  // R4: buffer write and commit never coincide
  p_we_commit_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({buf_we_o, commit_o}));
endmodule

bind twi_mem_slave twi_mem_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .start_i(start_i),
  .stop_i(stop_i), .busy_i(busy_i), .sda_pull_o(sda_pull_o),
  .buf_we_o(buf_we_o), .commit_o(commit_o)
);

// File: tb/twi_mem_slave_tb_top.sv
module twi_mem_slave_tb_top;
  localparam int H = 4;
  localparam int BUSY_CYC = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, start_p = 1'b0, stop_p = 1'b0;
  logic [7:0] rd_addr, rd_data, buf_addr, buf_data;
  logic sda_pull, buf_we, commit;
  logic busy;
  int busy_cnt = 0;
  int commits = 0;
  int n_chk = 0, n_err = 0;
  logic [7:0] mem [256];
  logic [7:0] pend_d [256];
  logic       pend_v [256];
  wire sda_line = sda_m & ~sda_pull;

  always #4 clk = ~clk;  // 125 MHz

  function automatic logic [7:0] init_val(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  assign busy    = busy_cnt != 0;
  assign rd_data = mem[rd_addr];

  twi_mem_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .start_i(start_p), .stop_i(stop_p), .busy_i(busy), .rd_data_i(rd_data),
    .sda_pull_o(sda_pull), .rd_addr_o(rd_addr), .buf_we_o(buf_we),
    .buf_addr_o(buf_addr), .buf_data_o(buf_data), .commit_o(commit)
  );

  // array, page buffer and programming timer model
  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = init_val(i);
      pend_v[i] = 1'b0;
      pend_d[i] = 8'h00;
    end
  end

  always @(posedge clk) begin
    if (buf_we) begin
      pend_d[buf_addr] = buf_data;
      pend_v[buf_addr] = 1'b1;
    end
    if (commit) begin
      commits++;
      for (int i = 0; i < 256; i++) if (pend_v[i]) begin
        mem[i] = pend_d[i];
        pend_v[i] = 1'b0;
      end
      busy_cnt = BUSY_CYC;
    end else if (busy_cnt > 0) busy_cnt--;
  end

  task automatic check(input int act, input int exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wait_h;
    repeat (H) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wait_h;
    scl = 1'b1; wait_h;
    sda_m = 1'b0; start_p = 1'b1; @(negedge clk); start_p = 1'b0;
    wait_h;
    scl = 1'b0;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wait_h;
    scl = 1'b1; wait_h;
    sda_m = 1'b1; stop_p = 1'b1; @(negedge clk); stop_p = 1'b0;
    wait_h;
  endtask

  task automatic clk_bit(input logic b, output logic r);
    sda_m = b; wait_h;
    scl = 1'b1; wait_h;
    r = sda_line;
    scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic r;
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, r);
      b = {b[6:0], r};
    end
    clk_bit(~mack, r);
    sda_m = 1'b1;
  endtask

  task automatic set_addr_read(input logic [7:0] a);
    logic ack;
    bus_start; send_byte(8'hA0, ack); check(int'(ack), 1, "R1 ctrl ack");
    send_byte(a, ack); check(int'(ack), 1, "R2 addr ack");
    bus_start; send_byte(8'hA1, ack); check(int'(ack), 1, "R6 read ctrl ack");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    logic r;
    int c0, polls;
    repeat (3) @(negedge clk);
    check(int'(sda_pull), 0, "R2 reset pull");
    rst_n = 1'b1;
    scl = 1'b0;
    wait_h;
    check(int'(sda_pull), 0, "R2 idle pull");
    check(commits, 0, "R5 no commit at reset");

    // R1: wrong device code, then following byte ignored
    bus_start; send_byte(8'h50, ack); check(int'(ack), 0, "R1 bad code nack");
    send_byte(8'hA0, ack); check(int'(ack), 0, "R1 ignored until START");
    bus_stop;

    // R1 sweep of the device-code nibble; R5 no commit without data
    c0 = commits;
    for (int n = 0; n < 16; n++) begin
      bus_start; send_byte({4'(n), 3'b101, 1'b0}, ack);
      check(int'(ack), int'(n == 10), "R1 code sweep ack");
      bus_stop;
    end
    check(commits, c0, "R5 no commit without data");

    // R4/R5: page write at 0x10 with chip-select bits set
    c0 = commits;
    bus_start; send_byte(8'hAE, ack); check(int'(ack), 1, "R1 cs bits ignored");
    send_byte(8'h10, ack); check(int'(ack), 1, "R2 addr ack");
    for (int i = 0; i < 3; i++) begin
      send_byte(8'hC1 + 8'(i), ack); check(int'(ack), 1, "R4 data ack");
    end
    bus_stop;
    check(commits, c0 + 1, "R5 commit on STOP");

    // R3: acknowledge polling
    polls = 0;
    for (int p = 0; p < 40; p++) begin
      bus_start; send_byte(8'hA0, ack); bus_stop;
      if (ack) break;
      polls++;
    end
    check(int'(polls > 0), 1, "R3 nack while busy");
    check(int'(busy), 0, "R3 ack after busy");

    // R7: current-address read continues after the write
    bus_start; send_byte(8'hA1, ack); check(int'(ack), 1, "R7 ctrl ack");
    recv_byte(1'b0, d); check(int'(d), int'(init_val(8'h13)), "R7 current read");
    check(int'(sda_pull), 0, "R8 released after nack");
    bus_stop;

    // R6/R8: random then sequential read of written data
    set_addr_read(8'h10);
    recv_byte(1'b1, d); check(int'(d), 'hC1, "R6 random read");
    recv_byte(1'b1, d); check(int'(d), 'hC2, "R8 sequential");
    recv_byte(1'b0, d); check(int'(d), 'hC3, "R8 last byte");
    send_byte(8'h00, ack); check(int'(ack), 0, "R8 idle after nack");
    bus_stop;

    // R9: wrap
    set_addr_read(8'hFE);
    for (int i = 0; i < 4; i++) begin
      recv_byte(i != 3, d);
      check(int'(d), int'(init_val((254 + i) & 255)), "R9 wrap read");
    end
    bus_stop;

    // R10: STOP inside a data byte
    c0 = commits;
    bus_start; send_byte(8'hA0, ack); send_byte(8'h40, ack);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, r);
    bus_stop;
    check(commits, c0, "R10 aborted byte not committed");
    check(int'(sda_pull), 0, "R10 released after STOP");

    // R10: START inside a read byte keeps pointer
    set_addr_read(8'h40);
    for (int i = 0; i < 3; i++) clk_bit(1'b1, r);
    bus_start; send_byte(8'hA1, ack); check(int'(ack), 1, "R10 restart ack");
    recv_byte(1'b0, d); check(int'(d), int'(init_val(8'h40)), "R10 pointer kept");
    bus_stop;

    // R8/R9: whole array in one transaction
    set_addr_read(8'h00);
    for (int i = 0; i < 256; i++) begin
      recv_byte(i != 255, d);
      check(int'(d), int'(mem[i]), "R9 full array read");
    end
    bus_stop;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule